// File: doc/BRIEF.md
# Paging Address Translation Unit with Page-Indexed Cache

This block turns 24-bit virtual byte addresses into physical addresses using 4 KiB pages. Every page index has its own slot in a translation cache. Because that cache is indexed directly by the page number, it needs no tag. When a slot is empty, the block fetches the translation record from memory. The virtual space is divided into four quarters, and each quarter has its own table base and its own enable, both supplied from outside.

A miss reads a 32-bit record as two 16-bit words over a simple read port, upper word first. The record is kept in the cache and then checked for presence and write permission. Each request gets exactly one response, which is one of:
- a translated address,
- a bus-error fault,
- an "unmapped" result.

Two invalidate inputs drop cached records. One drops a whole quarter at once and the other drops a single page. When translation is switched off, addresses pass through unchanged.

Top module: `pgx_translator`

## Requirements
- R1: When `xlat_en` is low, an accepted request is answered one cycle after acceptance with kind OK (0) and `rsp_paddr` equal to `req_vaddr`, and no memory read is made.
- R2: A request whose page index (vaddr bits 23:12) holds a valid cached record is answered one cycle after acceptance from that record, and no memory read is made.
- R3: On a miss whose quarter (page index bits 11:10) has its `qbase_en` bit low:
  - the answer is kind UNMAPPED (1), one cycle after acceptance, with no read;
  - nothing is cached, so the next access to that page after enabling the quarter fetches from memory.
- R4: The walk address for the upper word is the quarter base frame (`qbase_frame` field q, bits q*12 +: 12) shifted left 12, ORed with page index bits 9:0 shifted left 2.
  - The lower word is then read at that address + 2.
  - `mem_rd_req` and `mem_rd_addr` stay steady until `mem_rd_ack`.
- R5: The record is {upper, lower}. Bit 0 is present, bit 1 is writable, and bits 23:12 are the frame; all other bits are ignored. The record is cached even when it is not present, so a later access to that page is a hit.
- R6: The outcome of a record is decided as follows, and any non-OK answer carries `rsp_paddr` of 0:
  - not present: UNMAPPED (1);
  - present, and the access is a write to a non-writable record: BUSERR (2);
  - present, and the access is a read of a non-writable record: OK.
- R7: A successful translation returns the frame shifted left 12, ORed with vaddr bits 11:0.
- R8: A fetched answer is registered one cycle after the cycle in which the lower word's `mem_rd_ack` arrives, and `rsp_valid` stays low while the walk waits.
- R9: The invalidate pulses clear cached records, and the clearing affects lookups from the next cycle on:
  - `inv_quarter` clears every cached record of quarter `inv_quarter_sel`;
  - `inv_page` clears the one record at `inv_page_idx` and leaves the others.
- R10: An invalidate that covers the page being filled in the same cycle wins, and the page stays uncached.
- R11: A `mem_rd_err` on either word ends the request with BUSERR one cycle later and leaves that page uncached.
- R12: `req_ready` is high only while no walk is in progress, and a request presented during a walk is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_en | input | 1 | Global translation enable |
| qbase_en | input | 4 | Per-quarter table enable |
| qbase_frame | input | 48 | Per-quarter table base frame, 12 bits each |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_vaddr | input | 24 | Virtual byte address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | 0 OK, 1 UNMAPPED, 2 BUSERR |
| rsp_paddr | output | 24 | Physical address, 0 on fault |
| mem_rd_req | output | 1 | Table word read request |
| mem_rd_addr | output | 24 | Table word byte address |
| mem_rd_ack | input | 1 | Read completes this cycle |
| mem_rd_err | input | 1 | Read failed, valid with ack |
| mem_rd_data | input | 16 | Read word, valid with ack |
| inv_quarter | input | 1 | Clear all cached records of a quarter |
| inv_quarter_sel | input | 2 | Quarter to clear |
| inv_page | input | 1 | Clear one cached record |
| inv_page_idx | input | 12 | Page index to clear |

## Verification
The assertions take some things for granted about the inputs:
- `mem_rd_ack` and `mem_rd_err` arrive only while `mem_rd_req` is high.
- Each request is held for at most its acceptance cycle.
- A walk's quarter base is latched at acceptance, so later changes to it do not matter.

The stimulus keeps within these limits. It raises ack only during the walk phases it expects, and it drops the request the cycle after acceptance. The one exception is deliberate: during walk wait cycles it presents a stray request to show that the request is refused.

// File: rtl/pgx_pkg.sv
// Shared types and record field positions for the paging translation unit.
// Assumes a 32-bit table record fetched as two 16-bit words.
package pgx_pkg;

    typedef enum logic [1:0] {
        RSP_OK     = 2'd0,
        RSP_NOMAP  = 2'd1,
        RSP_BUSERR = 2'd2
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2
    } walk_st_e;

    localparam int WORD_W        = 16;
    localparam int ENT_W         = 2 * WORD_W;
    localparam int ENT_PRESENT   = 0;
    localparam int ENT_WRITABLE  = 1;
    localparam int ENT_FRAME_LSB = 12;

endpackage

// File: rtl/pgx_valid_bits.sv
// Valid flags of the page-indexed translation cache, one per page index.
// Each quarter can be cleared in one cycle, and a single page can be cleared.
// Assumes QSEL_W <= IDX_W; a clear always overrides a fill of the same slot.
module pgx_valid_bits #(
    parameter int IDX_W  = 12,
    parameter int QSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic              fpg_en,
    input  logic [IDX_W-1:0]  fpg_idx,
    input  logic              fq_en,
    input  logic [QSEL_W-1:0] fq_sel
);
    localparam int NQ     = 1 << QSEL_W;
    localparam int QIDX_W = IDX_W - QSEL_W;
    localparam int QDEPTH = 1 << QIDX_W;

    logic [NQ-1:0][QDEPTH-1:0] vq;

    for (genvar q = 0; q < NQ; q++) begin : g_quarter
        logic [QDEPTH-1:0] bits_q;
        logic              fill_here;
        logic              fpg_here;

        assign fill_here = fill_en && (fill_idx[IDX_W-1 -: QSEL_W] == QSEL_W'(q));
        assign fpg_here  = fpg_en  && (fpg_idx[IDX_W-1 -: QSEL_W] == QSEL_W'(q));

        // Per-quarter flags: a quarter clear wins, then a page clear over a fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q <= '0;
            end else if (fq_en && (fq_sel == QSEL_W'(q))) begin
                bits_q <= '0;
            end else begin
                if (fill_here) bits_q[fill_idx[QIDX_W-1:0]] <= 1'b1;
                if (fpg_here)  bits_q[fpg_idx[QIDX_W-1:0]]  <= 1'b0;
            end
        end

        assign vq[q] = bits_q;
    end

    // Lookup of the flag for the presented page index.
    always_comb begin
        rd_valid = vq[rd_idx[IDX_W-1 -: QSEL_W]][rd_idx[QIDX_W-1:0]];
    end

endmodule

// File: rtl/pgx_entry_store.sv
// Record storage of the translation cache: frame and permission bits per page.
// Holds no reset; the valid flags decide whether a slot is meaningful.
module pgx_entry_store #(
    parameter int IDX_W = 12,
    parameter int DW    = 14
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];

    // Write port: store a fetched record.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Read port: asynchronous lookup.
    always_comb begin
        rd_data = mem[rd_idx];
    end

endmodule

// File: rtl/pgx_perm_check.sv
// Turns a record and an access type into a response kind and a physical address.
// Purely combinational; a faulting response carries address zero.
module pgx_perm_check
    import pgx_pkg::*;
#(
    parameter int FR_W  = 12,
    parameter int OFS_W = 12
) (
    input  logic              present,
    input  logic              writable,
    input  logic [FR_W-1:0]   frame,
    input  logic              is_write,
    input  logic [OFS_W-1:0]  offset,
    output rsp_kind_e         kind,
    output logic [FR_W+OFS_W-1:0] paddr
);
    // Decide the outcome: not present, then write protection, then success.
    always_comb begin
        if (!present) begin
            kind  = RSP_NOMAP;
            paddr = '0;
        end else if (is_write && !writable) begin
            kind  = RSP_BUSERR;
            paddr = '0;
        end else begin
            kind  = RSP_OK;
            paddr = {frame, offset};
        end
    end

endmodule

// File: rtl/pgx_translator.sv
// Paging translation unit: a page-indexed cache in front of a two-word table fetch.
// Assumes PA_W == VA_W, and that the record offset bits fit in one page offset.
// Requests are taken only in the idle state; each gets one registered response.
module pgx_translator
    import pgx_pkg::*;
#(
    parameter int VA_W   = 24,
    parameter int PA_W   = 24,
    parameter int OFS_W  = 12,
    parameter int QSEL_W = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              xlat_en,
    input  logic [(1<<QSEL_W)-1:0]            qbase_en,
    input  logic [(1<<QSEL_W)*(PA_W-OFS_W)-1:0] qbase_frame,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic [VA_W-1:0]                   req_vaddr,
    input  logic                              req_write,
    output logic                              rsp_valid,
    output logic [1:0]                        rsp_kind,
    output logic [PA_W-1:0]                   rsp_paddr,
    output logic                              mem_rd_req,
    output logic [PA_W-1:0]                   mem_rd_addr,
    input  logic                              mem_rd_ack,
    input  logic                              mem_rd_err,
    input  logic [WORD_W-1:0]                 mem_rd_data,
    input  logic                              inv_quarter,
    input  logic [QSEL_W-1:0]                 inv_quarter_sel,
    input  logic                              inv_page,
    input  logic [VA_W-OFS_W-1:0]             inv_page_idx
);
    localparam int IDX_W  = VA_W - OFS_W;
    localparam int QIDX_W = IDX_W - QSEL_W;
    localparam int FR_W   = PA_W - OFS_W;
    localparam int ST_W   = FR_W + 2;

    walk_st_e            st;
    logic [IDX_W-1:0]    cur_idx;
    logic [OFS_W-1:0]    cur_ofs;
    logic                cur_wr;
    logic [PA_W-1:0]     ent_addr;
    logic [WORD_W-1:0]   hi_word;

    logic [IDX_W-1:0]    req_idx;
    logic [QSEL_W-1:0]   req_q;
    logic                hit;
    logic [ST_W-1:0]     cached;
    logic [ENT_W-1:0]    ent_full;
    logic [ST_W-1:0]     fetched;
    logic                fill_en;
    logic                unused_ent;

    logic                ck_p, ck_w, ck_wr;
    logic [FR_W-1:0]     ck_frame;
    logic [OFS_W-1:0]    ck_ofs;
    rsp_kind_e           ck_kind;
    logic [PA_W-1:0]     ck_paddr;

    assign req_idx    = req_vaddr[VA_W-1:OFS_W];
    assign req_q      = req_idx[IDX_W-1 -: QSEL_W];
    assign ent_full   = {hi_word, mem_rd_data};
    assign unused_ent = ^ent_full;
    assign fetched    = {ent_full[ENT_FRAME_LSB +: FR_W], ent_full[ENT_WRITABLE], ent_full[ENT_PRESENT]};
    assign fill_en    = (st == ST_LO) && mem_rd_ack && !mem_rd_err;

    assign req_ready   = (st == ST_IDLE);
    assign mem_rd_req  = (st != ST_IDLE);
    assign mem_rd_addr = (st == ST_LO) ? ent_addr + PA_W'(2) : ent_addr;

    pgx_valid_bits #(.IDX_W(IDX_W), .QSEL_W(QSEL_W)) u_valid (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_valid (hit),
        .fill_en  (fill_en),
        .fill_idx (cur_idx),
        .fpg_en   (inv_page),
        .fpg_idx  (inv_page_idx),
        .fq_en    (inv_quarter),
        .fq_sel   (inv_quarter_sel)
    );

    pgx_entry_store #(.IDX_W(IDX_W), .DW(ST_W)) u_store (
        .clk     (clk),
        .wr_en   (fill_en),
        .wr_idx  (cur_idx),
        .wr_data (fetched),
        .rd_idx  (req_idx),
        .rd_data (cached)
    );

    // Check inputs: the cached record when idle, the fetched record otherwise.
    always_comb begin
        if (st == ST_IDLE) begin
            {ck_frame, ck_w, ck_p} = cached;
            ck_wr  = req_write;
            ck_ofs = req_vaddr[OFS_W-1:0];
        end else begin
            {ck_frame, ck_w, ck_p} = fetched;
            ck_wr  = cur_wr;
            ck_ofs = cur_ofs;
        end
    end

    pgx_perm_check #(.FR_W(FR_W), .OFS_W(OFS_W)) u_check (
        .present  (ck_p),
        .writable (ck_w),
        .frame    (ck_frame),
        .is_write (ck_wr),
        .offset   (ck_ofs),
        .kind     (ck_kind),
        .paddr    (ck_paddr)
    );

    // Walk state machine and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cur_idx   <= '0;
            cur_ofs   <= '0;
            cur_wr    <= 1'b0;
            ent_addr  <= '0;
            hi_word   <= '0;
            rsp_valid <= 1'b0;
            rsp_kind  <= RSP_OK;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!xlat_en) begin
                            rsp_valid <= 1'b1;
                            rsp_kind  <= RSP_OK;
                            rsp_paddr <= PA_W'(req_vaddr);
                        end else if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_kind  <= ck_kind;
                            rsp_paddr <= ck_paddr;
                        end else if (!qbase_en[req_q]) begin
                            rsp_valid <= 1'b1;
                            rsp_kind  <= RSP_NOMAP;
                            rsp_paddr <= '0;
                        end else begin
                            st       <= ST_HI;
                            cur_idx  <= req_idx;
                            cur_ofs  <= req_vaddr[OFS_W-1:0];
                            cur_wr   <= req_write;
                            ent_addr <= {qbase_frame[req_q*FR_W +: FR_W], OFS_W'(0)}
                                      | PA_W'({req_idx[QIDX_W-1:0], 2'b00});
                        end
                    end
                end
                ST_HI: begin
                    if (mem_rd_ack) begin
                        if (mem_rd_err) begin
                            st        <= ST_IDLE;
                            rsp_valid <= 1'b1;
                            rsp_kind  <= RSP_BUSERR;
                            rsp_paddr <= '0;
                        end else begin
                            st      <= ST_LO;
                            hi_word <= mem_rd_data;
                        end
                    end
                end
                ST_LO: begin
                    if (mem_rd_ack) begin
                        st        <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        if (mem_rd_err) begin
                            rsp_kind  <= RSP_BUSERR;
                            rsp_paddr <= '0;
                        end else begin
                            rsp_kind  <= ck_kind;
                            rsp_paddr <= ck_paddr;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pgx_translator_chk.sv
// Protocol and response checks for pgx_translator, attached by bind.
// Assumes acks arrive only while a read is requested.
module pgx_translator_chk
    import pgx_pkg::*;
#(
    parameter int VA_W  = 24,
    parameter int PA_W  = 24,
    parameter int OFS_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xlat_en,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             rsp_valid,
    input logic [1:0]       rsp_kind,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             mem_rd_req,
    input logic [PA_W-1:0]  mem_rd_addr,
    input logic             mem_rd_ack,
    input logic             mem_rd_err
);
    logic             lo_phase;
    logic [OFS_W-1:0] acc_ofs;

    // Track which word of the record the next ack completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   lo_phase <= 1'b0;
        else if (mem_rd_req && mem_rd_ack)            lo_phase <= mem_rd_err ? 1'b0 : !lo_phase;
    end

    // Remember the page offset of the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                       acc_ofs <= '0;
        else if (req_valid && req_ready)  acc_ofs <= req_vaddr[OFS_W-1:0];
    end

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlat_en) |=> (rsp_valid && rsp_kind == RSP_OK && rsp_paddr == PA_W'($past(req_vaddr)))); // R1
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr))); // R4
    AST_LO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ack && !mem_rd_err && !lo_phase) |=> (mem_rd_req && mem_rd_addr == $past(mem_rd_addr) + PA_W'(2))); // R4
    AST_ERR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ack && mem_rd_err) |=> (rsp_valid && rsp_kind == RSP_BUSERR)); // R11
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != RSP_OK) |-> (rsp_paddr == '0)); // R6
    AST_WALK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> !rsp_valid); // R8
    AST_OFS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RSP_OK) |-> (rsp_paddr[OFS_W-1:0] == acc_ofs)); // R7
    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready); // R12

endmodule

bind pgx_translator pgx_translator_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xlat_en     (xlat_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .rsp_valid   (rsp_valid),
    .rsp_kind    (rsp_kind),
    .rsp_paddr   (rsp_paddr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_err  (mem_rd_err)
);

// File: tb/pgx_translator_tb.sv
// Bench for pgx_translator: a behavioural model sets expected outputs,
// and a monitor compares them on every falling clock edge.
module pgx_translator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b0;
    logic [3:0]  qbase_en = '0;
    logic [47:0] qbase_frame = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_kind;
    logic [23:0] rsp_paddr;
    logic        mem_rd_req;
    logic [23:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic        mem_rd_err = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic        inv_quarter = 1'b0;
    logic [1:0]  inv_quarter_sel = '0;
    logic        inv_page = 1'b0;
    logic [11:0] inv_page_idx = '0;

    pgx_translator u_dut (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .qbase_en(qbase_en),
        .qbase_frame(qbase_frame), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_paddr(rsp_paddr), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_err(mem_rd_err),
        .mem_rd_data(mem_rd_data), .inv_quarter(inv_quarter),
        .inv_quarter_sel(inv_quarter_sel), .inv_page(inv_page), .inv_page_idx(inv_page_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state
    bit          ref_v [4096];
    logic [31:0] ref_e [4096];
    bit          exp_rv = 0;
    logic [1:0]  exp_kind = 0;
    logic [23:0] exp_pa = 0;
    bit          exp_mv = 0;
    logic [23:0] exp_ma = 0;
    string       exp_tag = "R1";

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(rsp_valid == exp_rv, exp_tag, "rsp_valid", rsp_valid, exp_rv);
            if (exp_rv && rsp_valid) begin
                check(rsp_kind == exp_kind, exp_tag, "rsp_kind", rsp_kind, exp_kind);
                check(rsp_paddr == exp_pa, exp_tag, "rsp_paddr", rsp_paddr, exp_pa);
            end
            check(mem_rd_req == exp_mv, exp_tag, "mem_rd_req", mem_rd_req, exp_mv);
            if (exp_mv && mem_rd_req)
                check(mem_rd_addr == exp_ma, exp_tag, "mem_rd_addr", mem_rd_addr, exp_ma);
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Outcome of a record per R5/R6/R7.
    task automatic expect_rec(input logic [31:0] e, input bit wr, input logic [23:0] va);
        if (!e[0]) begin exp_kind = 2'd1; exp_pa = '0; end
        else if (wr && !e[1]) begin exp_kind = 2'd2; exp_pa = '0; end
        else begin exp_kind = 2'd0; exp_pa = {e[23:12], va[11:0]}; end
    endtask

    task automatic respond(input string tag);
        exp_tag = tag; exp_rv = 1;
        step();
        exp_rv = 0;
    endtask

    // One request; walk parameters apply only if the model predicts a miss.
    // fl: 0 none, 1 page invalidate of this page, 2 quarter invalidate, with the low-word ack.
    task automatic access(input logic [23:0] va, input bit wr, input int lat,
                          input bit eh, input bit el, input logic [15:0] hi,
                          input logic [15:0] lo, input bit stray, input int fl,
                          input string tag);
        logic [11:0] idx;
        logic [1:0]  q;
        logic [23:0] ea;
        idx = va[23:12];
        q = idx[11:10];
        check(req_ready == 1'b1, "R12", "req_ready idle", req_ready, 1);
        req_valid = 1; req_vaddr = va; req_write = wr;
        step();
        req_valid = 0;
        exp_tag = tag;
        if (!xlat_en) begin
            exp_kind = 0; exp_pa = va; respond(tag);
        end else if (ref_v[idx]) begin
            expect_rec(ref_e[idx], wr, va); respond(tag);
        end else if (!qbase_en[q]) begin
            exp_kind = 1; exp_pa = 0; respond(tag);
        end else begin
            ea = {qbase_frame[q*12 +: 12], 12'h000} | {12'h000, idx[9:0], 2'b00};
            exp_mv = 1; exp_ma = ea;
            for (int k = 0; k < lat; k++) begin
                if (stray) begin req_valid = 1; req_vaddr = va ^ 24'h00F000; end
                step();
                if (stray) check(req_ready == 1'b0, "R12", "req_ready busy", req_ready, 0);
            end
            req_valid = 0;
            mem_rd_ack = 1; mem_rd_err = eh; mem_rd_data = hi;
            step();
            mem_rd_ack = 0; mem_rd_err = 0;
            if (eh) begin
                exp_mv = 0; exp_kind = 2; exp_pa = 0; respond(tag);
                return;
            end
            exp_ma = ea + 24'd2;
            for (int k = 0; k < lat; k++) step();
            mem_rd_ack = 1; mem_rd_err = el; mem_rd_data = lo;
            if (fl == 1) begin inv_page = 1; inv_page_idx = idx; end
            if (fl == 2) begin inv_quarter = 1; inv_quarter_sel = q; end
            step();
            mem_rd_ack = 0; mem_rd_err = 0; inv_page = 0; inv_quarter = 0;
            exp_mv = 0;
            if (el) begin
                exp_kind = 2; exp_pa = 0;
            end else begin
                if (fl == 0) begin ref_v[idx] = 1; ref_e[idx] = {hi, lo}; end
                expect_rec({hi, lo}, wr, va);
            end
            respond(tag);
        end
    endtask

    task automatic flush_page(input logic [11:0] idx);
        inv_page = 1; inv_page_idx = idx;
        step();
        inv_page = 0; ref_v[idx] = 0;
    endtask

    task automatic flush_quarter(input logic [1:0] q);
        inv_quarter = 1; inv_quarter_sel = q;
        step();
        inv_quarter = 0;
        for (int i = 0; i < 1024; i++) ref_v[{q, 10'(i)}] = 0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) ref_v[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(req_ready == 1'b1, "R12", "reset req_ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R12", "reset rsp_valid", rsp_valid, 0);
        check(mem_rd_req == 1'b0, "R12", "reset mem_rd_req", mem_rd_req, 0);
        step();

        // R1: pass-through while disabled
        access(24'h123456, 1, 0, 0, 0, 0, 0, 0, 0, "R1");

        xlat_en = 1;
        qbase_en = 4'b1011;
        qbase_frame = {12'hF00, 12'h333, 12'h2A0, 12'h100};
        step();

        // R4 R5 R7 R8: miss, zero-latency fetch, ignored bits set in record
        access(24'h0057AB, 0, 0, 0, 0, 16'hC234, 16'h5FF3, 0, 0, "R7");
        // R2: hit, write allowed
        access(24'h005010, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R6 R12: write to read-only, latency 2, stray requests while busy
        access(24'h412ABC, 1, 2, 0, 0, 16'h00AB, 16'hC001, 1, 0, "R6");
        // R6: read of read-only hit is fine
        access(24'h412004, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
        // R3: quarter disabled
        access(24'h800123, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        qbase_en = 4'b1111;
        step();
        // R3 R6: now walks, record not present
        access(24'h800123, 0, 1, 0, 0, 16'hFFFF, 16'hF000, 0, 0, "R3");
        // R5: non-present record was cached
        access(24'h800FFF, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
        // R11: errors on upper then lower word, then a good fetch
        access(24'hC07100, 0, 1, 1, 0, 0, 0, 0, 0, "R11");
        access(24'hC07100, 0, 0, 0, 1, 16'h0001, 16'h2003, 0, 0, "R11");
        access(24'hC07100, 1, 3, 0, 0, 16'h0001, 16'h2003, 0, 0, "R11");
        // R9: quarter clear and page clear
        flush_quarter(2'd0);
        access(24'h005222, 0, 0, 0, 0, 16'h0077, 16'h7001, 0, 0, "R9");
        flush_page(12'h412);
        access(24'h412000, 0, 0, 0, 0, 16'h0011, 16'h1003, 0, 0, "R9");
        access(24'hC07FFE, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        access(24'h005333, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
        // R10: invalidate in the fill cycle wins
        access(24'hC10040, 0, 1, 0, 0, 16'h0042, 16'h4003, 0, 1, "R10");
        access(24'hC10040, 0, 0, 0, 0, 16'h0043, 16'h5003, 0, 0, "R10");
        access(24'h7FF000, 0, 0, 0, 0, 16'h00AA, 16'hB003, 0, 2, "R10");
        access(24'h7FF000, 0, 0, 0, 0, 16'h00AA, 16'hC003, 0, 0, "R10");
        // R1: disabling bypasses cached records
        xlat_en = 0;
        step();
        access(24'h0057AB, 1, 0, 0, 0, 0, 0, 0, 0, "R1");

        repeat (3) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule